// File: doc/BRIEF.md
# Clock Generation Control Sequencer

This block is the control and status front end of a clock generation unit. Software reaches it through a small register bus with three registers. The control register holds the bypass bit, the hold-for-idle bit, the PLL multiplier and the input-divide value. The divider register holds several clock divisor select fields and an update bit. The status register reports the phase of the sequencer and two sticky error flags. The block does not model the PLL itself. Lock time and alignment time are cycle counters, and the values presented to the clock tree are the "active" outputs, which load only at defined points in the sequence.

A change to the multiplier or to the input divide puts the PLL into bypass and starts a relock. Every relock is followed by an alignment of all clocks. If the hold-for-idle bit is set, the relock waits until every core reports idle. A divider write with the update bit set starts an alignment on its own. With the update bit clear, the new divisors are held and applied at the next relock, so only one alignment takes place. Some writes are illegal: a multiplier or divide change while the PLL is locking, and a divider write while the clocks are aligning. Such a write still updates the register. It starts no new sequence and sets a sticky error flag, which software clears by writing 1 to it.

Top module: `clkgen_seq`

## Requirements
- R1: After reset the sequencer is in bypass with `pll_bypass`=1. Control reads 0x1001: bypass bit 0 is 1, hold bit 1 is 0, multiplier field [8 +: MULT_W] is 16, input-divide field [16 +: IDIV_W] is 0. Divider reads 0x321: select field i at [i*SEL_W +: SEL_W] holds i+1, and update bit 31 is 0. Status bits [4:0] read 0x07.
- R2: The status low bits are: bit0 PLL enabled (always 1), bit1 bypassed (1 outside full-on), bit2 not-locking, bit3 aligning, bit4 waiting for idle. Clearing the bypass bit while in bypass runs ALIGN_CYC cycles of alignment (low nibble 0xF), and then the low nibble reads 0x5 with `pll_bypass`=0. Setting the bypass bit while in full-on returns to bypass (0x07).
- R3: A control write that changes the multiplier or the input divide, made outside locking, enters locking (low nibble 0x3) on that clock edge. It stays there for LOCK_CYC cycles, and `act_mult` and `act_idiv` take the new values on that edge.
- R4: Every completed lock is followed by ALIGN_CYC cycles of alignment. The sequencer then goes to full-on (0x5), or back to bypass if the bypass bit is set. `act_mult` and `act_idiv` change only on entry to locking.
- R5: A control write during locking that changes the multiplier or the input divide sets sticky status bit 8. It does not restart locking and does not change `act_mult`. A control write that leaves both fields unchanged sets no error.
- R6: Any divider write during alignment sets sticky status bit 9. It does not restart or lengthen the alignment and does not change `act_sel`.
- R7: Writing status with bit 8 or bit 9 at 1 clears that error bit. Writing 0 leaves it set.
- R8: A read of the control or divider register returns the value last written, even while the resulting sequence is still pending.
- R9: If the hold bit is set when a relock is due and not every `core_idle` bit is 1, the sequencer waits (status 0x17) with `act_mult` unchanged. It enters locking on the first edge on which all `core_idle` bits are 1.
- R10: A divider write with bit 31 set, made in full-on or bypass, starts an alignment and loads `act_sel` on that edge. With bit 31 clear, `act_sel` keeps its value until the next relock's alignment starts. At that point it loads, with a single alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 divider, 2 status |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_idle | input | NCORE | One idle-or-reset indication per core |
| pll_bypass | output | 1 | PLL output bypassed (every phase except full-on) |
| act_mult | output | MULT_W | Multiplier applied to the PLL |
| act_idiv | output | IDIV_W | Input divide applied to the PLL |
| act_sel | output | NDIV*SEL_W | Divisor selects applied to the clock tree |
| align_busy | output | 1 | Alignment in progress |

## Verification
A register write acts on the clock edge that samples the strobe, so phase changes and active-value loads show at the first falling edge after that write. The bench numbers samples from that edge and predicts each one arithmetically. Samples 0 to LOCK_CYC-1 show locking, the next ALIGN_CYC samples show aligning, and full-on follows. Error flags and readback values are checked at sample 0 after the offending write. Illegal writes are placed at a known sample index, so that the unchanged end of the sequence proves there was no restart.

// File: rtl/clkgen_seq.sv
module clkgen_seq #(
  parameter int MULT_W    = 7,
  parameter int IDIV_W    = 2,
  parameter int SEL_W     = 4,
  parameter int NDIV      = 3,
  parameter int NCORE     = 2,
  parameter int LOCK_CYC  = 8,
  parameter int ALIGN_CYC = 4,
  parameter int MULT_RST  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NCORE-1:0]        core_idle,
  output logic                    pll_bypass,
  output logic [MULT_W-1:0]       act_mult,
  output logic [IDIV_W-1:0]       act_idiv,
  output logic [NDIV*SEL_W-1:0]   act_sel,
  output logic                    align_busy
);
  localparam int SELS_W = NDIV * SEL_W;
  localparam int CMAX   = (LOCK_CYC > ALIGN_CYC) ? LOCK_CYC : ALIGN_CYC;
  localparam int CNT_W  = $clog2(CMAX + 1);

  function automatic logic [SELS_W-1:0] sel_rst();
    logic [SELS_W-1:0] r;
    r = '0;
    for (int i = 0; i < NDIV; i++) r[i*SEL_W +: SEL_W] = SEL_W'(i + 1);
    return r;
  endfunction
  localparam logic [SELS_W-1:0] SEL_RST = sel_rst();

  typedef enum logic [2:0] {S_BYP, S_WAIT, S_LOCK, S_ALGN, S_FULL} st_t;

  st_t               state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic              ctl_byp, ctl_hold, div_upd, err_md, err_dv;
  logic [MULT_W-1:0] ctl_mult;
  logic [IDIV_W-1:0] ctl_idiv;
  logic [SELS_W-1:0] div_sel;

  wire wr_ctl = bus_wr && bus_addr == 2'd0;
  wire wr_div = bus_wr && bus_addr == 2'd1;
  wire wr_st  = bus_wr && bus_addr == 2'd2;
  wire [MULT_W-1:0] w_mult = bus_wdata[8 +: MULT_W];
  wire [IDIV_W-1:0] w_idiv = bus_wdata[16 +: IDIV_W];
  wire [SELS_W-1:0] w_sel  = bus_wdata[SELS_W-1:0];
  wire fchg     = wr_ctl && (w_mult != ctl_mult || w_idiv != ctl_idiv);
  wire idle_all = &core_idle;
  wire lock_end = cnt == CNT_W'(LOCK_CYC - 1);
  wire algn_end = cnt == CNT_W'(ALIGN_CYC - 1);
  wire st_t go_lock = (bus_wdata[1] && !idle_all) ? S_WAIT : S_LOCK;

  always_comb begin
    nxt = state;
    case (state)
      S_BYP:  if (fchg) nxt = go_lock;
              else if (wr_ctl && !bus_wdata[0]) nxt = S_ALGN;
              else if (wr_div && bus_wdata[31]) nxt = S_ALGN;
      S_FULL: if (fchg) nxt = go_lock;
              else if (wr_ctl && bus_wdata[0]) nxt = S_BYP;
              else if (wr_div && bus_wdata[31]) nxt = S_ALGN;
      S_WAIT: if (idle_all || !ctl_hold) nxt = S_LOCK;
      S_LOCK: if (lock_end) nxt = S_ALGN;
      S_ALGN: if (fchg) nxt = go_lock;
              else if (algn_end) nxt = ctl_byp ? S_BYP : S_FULL;
      default: nxt = S_BYP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_BYP;
      cnt      <= '0;
      ctl_byp  <= 1'b1;
      ctl_hold <= 1'b0;
      ctl_mult <= MULT_W'(MULT_RST);
      ctl_idiv <= '0;
      div_sel  <= SEL_RST;
      div_upd  <= 1'b0;
      err_md   <= 1'b0;
      err_dv   <= 1'b0;
      act_mult <= MULT_W'(MULT_RST);
      act_idiv <= '0;
      act_sel  <= SEL_RST;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if (state == S_LOCK || state == S_ALGN) cnt <= cnt + 1'b1;
      if (wr_ctl) begin
        ctl_byp  <= bus_wdata[0];
        ctl_hold <= bus_wdata[1];
        ctl_mult <= w_mult;
        ctl_idiv <= w_idiv;
      end
      if (wr_div) begin
        div_sel <= w_sel;
        div_upd <= bus_wdata[31];
      end
      if (fchg && state == S_LOCK) err_md <= 1'b1;
      else if (wr_st && bus_wdata[8]) err_md <= 1'b0;
      if (wr_div && state == S_ALGN) err_dv <= 1'b1;
      else if (wr_st && bus_wdata[9]) err_dv <= 1'b0;
      if (nxt == S_LOCK && state != S_LOCK) begin
        act_mult <= wr_ctl ? w_mult : ctl_mult;
        act_idiv <= wr_ctl ? w_idiv : ctl_idiv;
      end
      if (nxt == S_ALGN && state != S_ALGN) act_sel <= wr_div ? w_sel : div_sel;
    end
  end

  logic [31:0] ctl_word, div_word, st_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[0] = ctl_byp;
    ctl_word[1] = ctl_hold;
    ctl_word[8 +: MULT_W] = ctl_mult;
    ctl_word[16 +: IDIV_W] = ctl_idiv;
    div_word = '0;
    div_word[SELS_W-1:0] = div_sel;
    div_word[31] = div_upd;
    st_word = '0;
    st_word[0] = 1'b1;
    st_word[1] = state != S_FULL;
    st_word[2] = state != S_LOCK;
    st_word[3] = state == S_ALGN;
    st_word[4] = state == S_WAIT;
    st_word[8] = err_md;
    st_word[9] = err_dv;
  end

  assign bus_rdata  = bus_addr == 2'd0 ? ctl_word :
                      bus_addr == 2'd1 ? div_word :
                      bus_addr == 2'd2 ? st_word  : 32'h0;
  assign pll_bypass = state != S_FULL;
  assign align_busy = state == S_ALGN;

  p_lock_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state) == S_LOCK && state != S_LOCK |-> state == S_ALGN);
  p_full_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FULL && $past(state) != S_FULL |-> $past(state) == S_ALGN);
  p_mult_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_LOCK |-> $stable(act_mult) && $stable(act_idiv));
  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_ALGN |-> $stable(act_sel));
  p_wait_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT && idle_all |=> state == S_LOCK);
  p_err_md_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_md) |-> $past(state) == S_LOCK && $past(wr_ctl));
  p_err_dv_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_dv) |-> $past(state) == S_ALGN && $past(wr_div));
endmodule

// File: tb/tb_clkgen_seq.sv
module tb_clkgen_seq;
  localparam int L = 8, A = 4;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata, v;
  logic [1:0]  core_idle = 2'b00;
  logic        pll_bypass, align_busy;
  logic [6:0]  act_mult;
  logic [1:0]  act_idiv;
  logic [11:0] act_sel;
  int total = 0, bad = 0;

  clkgen_seq #(.MULT_W(7), .IDIV_W(2), .SEL_W(4), .NDIV(3), .NCORE(2),
               .LOCK_CYC(L), .ALIGN_CYC(A), .MULT_RST(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_idle(core_idle),
    .pll_bypass(pll_bypass), .act_mult(act_mult), .act_idiv(act_idiv),
    .act_sel(act_sel), .align_busy(align_busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input int m, input int dv, input bit h, input bit b);
    return (32'(dv) << 16) | (32'(m) << 8) | (32'(h) << 1) | 32'(b);
  endfunction

  function automatic logic [3:0] code(input int j, input int lk, input bit byp_end);
    if (j < lk) return 4'h3;
    if (j < lk + A) return 4'hF;
    return byp_end ? 4'h7 : 4'h5;
  endfunction

  task automatic sweep(input int s, input int n, input int lk, input bit be, input string req);
    logic [31:0] x;
    for (int j = s; j < s + n; j++) begin
      @(negedge clk);
      rd(2'd2, x);
      chk(req, {28'h0, x[3:0]}, {28'h0, code(j, lk, be)});
    end
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl", v, 32'h1001);
    rd(2'd1, v); chk("R1 div", v, 32'h321);
    rd(2'd2, v); chk("R1 status", {27'h0, v[4:0]}, 32'h07);
    chk("R1 bypass", {31'h0, pll_bypass}, 32'h1);
    chk("R1 mult", {25'h0, act_mult}, 32'd16);
    chk("R1 sel", {20'h0, act_sel}, 32'h321);

    wr(2'd0, ctl(16, 0, 0, 0));
    sweep(0, A + 2, 0, 0, "R2 exit bypass");
    chk("R2 bypass low", {31'h0, pll_bypass}, 32'h0);

    for (int k = 0; k < 3; k++) begin
      wr(2'd0, ctl(20 + 9 * k, k, 0, 0));
      @(negedge clk);
      chk("R3 mult load", {25'h0, act_mult}, 32'(20 + 9 * k));
      chk("R3 idiv load", {30'h0, act_idiv}, 32'(k));
      rd(2'd2, v); chk("R3 locking", {28'h0, v[3:0]}, 32'h3);
      sweep(1, L + A, L, 0, "R4 relock+align");
    end

    wr(2'd1, 32'h8000_0456);
    sweep(0, A + 1, 0, 0, "R10 upd align");
    chk("R10 sel upd", {20'h0, act_sel}, 32'h456);
    rd(2'd1, v); chk("R8 div readback", v, 32'h8000_0456);

    wr(2'd1, 32'h0000_0723);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held sel", {20'h0, act_sel}, 32'h456);
    end
    rd(2'd1, v); chk("R8 div readback held", v, 32'h723);
    wr(2'd0, ctl(30, 1, 0, 0));
    for (int j = 0; j <= L + A; j++) begin
      @(negedge clk);
      rd(2'd2, v); chk("R10 single align", {28'h0, v[3:0]}, {28'h0, code(j, L, 0)});
      chk("R10 sel at relock", {20'h0, act_sel}, (j < L) ? 32'h456 : 32'h723);
    end

    wr(2'd0, ctl(40, 0, 0, 0));
    sweep(0, 2, L, 0, "R5 pre");
    wr(2'd0, ctl(50, 2, 0, 0));
    @(negedge clk);
    rd(2'd2, v);
    chk("R5 err set", {31'h0, v[8]}, 32'h1);
    chk("R5 still locking", {28'h0, v[3:0]}, 32'h3);
    rd(2'd0, v); chk("R8 ctrl readback", v, ctl(50, 2, 0, 0));
    chk("R5 mult kept", {25'h0, act_mult}, 32'd40);
    sweep(4, L + A - 3, L, 0, "R5 no restart");
    chk("R5 mult kept end", {25'h0, act_mult}, 32'd40);
    wr(2'd2, 32'h0);
    @(negedge clk); rd(2'd2, v); chk("R7 zero keeps", {31'h0, v[8]}, 32'h1);
    wr(2'd2, 32'h100);
    @(negedge clk); rd(2'd2, v); chk("R7 clear md", {31'h0, v[8]}, 32'h0);

    wr(2'd1, 32'h8000_0111);
    sweep(0, 1, 0, 0, "R6 pre");
    wr(2'd1, 32'h0000_0222);
    @(negedge clk);
    rd(2'd2, v);
    chk("R6 err set", {31'h0, v[9]}, 32'h1);
    chk("R6 aligning", {28'h0, v[3:0]}, 32'hF);
    chk("R6 sel kept", {20'h0, act_sel}, 32'h111);
    sweep(3, 2, 0, 0, "R6 no restart");
    wr(2'd2, 32'h200);
    @(negedge clk); rd(2'd2, v); chk("R7 clear dv", {30'h0, v[9:8]}, 32'h0);

    wr(2'd0, ctl(60, 0, 0, 0));
    sweep(0, 2, L, 0, "R5 pre2");
    wr(2'd0, ctl(60, 0, 0, 0));
    @(negedge clk); rd(2'd2, v);
    chk("R5 same value no err", {31'h0, v[8]}, 32'h0);
    sweep(4, L + A - 3, L, 0, "R5 same value");

    core_idle = 2'b01;
    wr(2'd0, ctl(70, 0, 1, 0));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      rd(2'd2, v); chk("R9 waiting", {27'h0, v[4:0]}, 32'h17);
      chk("R9 mult held", {25'h0, act_mult}, 32'd60);
    end
    core_idle = 2'b11;
    sweep(0, L + A + 1, L, 0, "R9 go after idle");
    chk("R9 mult load", {25'h0, act_mult}, 32'd70);

    wr(2'd0, ctl(70, 0, 1, 1));
    @(negedge clk); rd(2'd2, v);
    chk("R2 to bypass", {27'h0, v[4:0]}, 32'h07);
    chk("R2 bypass pin", {31'h0, pll_bypass}, 32'h1);

    wr(2'd0, ctl(80, 0, 0, 1));
    sweep(0, L + A + 1, L, 1, "R4 relock in bypass");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule